// File: doc/BRIEF.md
# Two-Key Register Write Unlock Guard

This block guards the configuration registers of a memory-mapped peripheral against stray writes. After reset the guard is locked. While it is locked, the write-enable qualifier it gives the protected registers stays low, so those registers ignore every bus write. Software opens the guard by writing two fixed 32-bit keys to two kick registers, the first key before the second. When the guard accepts the second key, it waits a short settling window and then raises its unlocked flag. Once open, it stays open until the next reset.

Software sees the result in one bit of the general control register. The usual flow is to write both keys and then poll that bit until it reads 1, giving up after a bounded time. The bus is a simple 32-bit word-addressed register port with separate write and read strobes. Read data appears one cycle after the read strobe. The protected registers are outside this block. It only supplies their write qualifier and the status bit.

Top module: `regkey_unlock_guard`

## Requirements
- R1: After reset is asserted, `unlocked` and `prot_wr_en` are 0 and `bus_rdata` is 0, whatever had been written before.
- R2: The guard opens when 0x83E70B13 is written to the first kick register (word address 0x1C, byte offset 0x70) and then 0x95A4F1E0 is written to the second kick register (word 0x1D, byte 0x74). `unlocked` rises exactly SETTLE_CYCLES clock edges after the edge that took the second key.
- R3: A read of the general control register (word 0x14, byte 0x50) returns `unlocked` in bit 23, with every other bit 0. The data appears on the cycle after the read strobe edge.
- R4: Reads of either kick register, or of any address other than the control register, return 0.
- R5: `prot_wr_en` is high in the same cycle as a bus write only when the guard is unlocked and the address is not a kick register. While the guard is locked it is never high.
- R6: Writing any value other than the first key to the first kick register cancels earlier progress, so a following correct second key does not unlock.
- R7: Writing any value other than the second key to the second kick register cancels progress, so a later correct second key without a fresh first key does not unlock.
- R8: The second key written without a preceding first key, or the two keys written in reverse order, does not unlock.
- R9: Once unlocked, the guard stays unlocked until reset. Further kick writes, with correct or wrong values, have no effect.
- R10: Writes to addresses other than the kick registers, between the two keys, leave progress intact, so the second key still unlocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, one word per cycle |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after the read strobe |
| unlocked | output | 1 | High once the key sequence has completed and settled |
| prot_wr_en | output | 1 | Write qualifier for the protected registers |

## Verification
Three results have different latencies, and each check waits for its own:
- `prot_wr_en` is combinational. The bench samples it in the same cycle as the write, one time step after it drives the strobe.
- Read data is due one edge after the read strobe. The driver queues the expected word. The monitor takes it from the queue on the falling edge after the edge that registered the read.
- `unlocked` is due SETTLE_CYCLES edges after the edge that took the second key. The bench checks it on every falling edge of that window: low until the last one, high on the last one. A rise that comes one cycle early or late is therefore caught.

// File: rtl/regkey_pkg.sv
package regkey_pkg;

  localparam int unsigned DATA_W = 32;

  // Key values and register byte offsets that software relies on
  localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h83E7_0B13;
  localparam logic [DATA_W-1:0] KEY_SECOND = 32'h95A4_F1E0;
  localparam logic [11:0] CTRL_BYTE_OFS       = 12'h050;
  localparam logic [11:0] KICK_FIRST_BYTE_OFS = 12'h070;
  localparam logic [11:0] KICK_SECOND_BYTE_OFS = 12'h074;
  localparam int unsigned STATUS_BIT = 23;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ARMED  = 2'd1,
    SEQ_SETTLE = 2'd2,
    SEQ_OPEN   = 2'd3
  } seq_state_e;

  // Byte offset to word index
  function automatic logic [9:0] word_of(input logic [11:0] byte_ofs);
    return byte_ofs[11:2];
  endfunction

  // Control register image as seen by this block
  function automatic logic [DATA_W-1:0] status_word(input logic open_flag);
    logic [DATA_W-1:0] w;
    w = '0;
    w[STATUS_BIT] = open_flag;
    return w;
  endfunction

  function automatic logic key_match(input logic [DATA_W-1:0] value,
                                     input logic [DATA_W-1:0] key);
    return value == key;
  endfunction

endpackage

// File: rtl/regkey_decode.sv
module regkey_decode #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_first,
  output logic              hit_second,
  output logic              hit_ctrl
);
  import regkey_pkg::*;

  localparam logic [ADDR_W-1:0] W_FIRST  = ADDR_W'(word_of(KICK_FIRST_BYTE_OFS));
  localparam logic [ADDR_W-1:0] W_SECOND = ADDR_W'(word_of(KICK_SECOND_BYTE_OFS));
  localparam logic [ADDR_W-1:0] W_CTRL   = ADDR_W'(word_of(CTRL_BYTE_OFS));

  always_comb begin
    hit_first  = (addr == W_FIRST);
    hit_second = (addr == W_SECOND);
    hit_ctrl   = (addr == W_CTRL);
  end
endmodule

// File: rtl/regkey_seq.sv
module regkey_seq #(
  parameter int unsigned SETTLE_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        hit_first,
  input  logic        hit_second,
  input  logic [31:0] wdata,
  output logic        unlocked,
  output logic        armed,
  output logic        settling,
  output logic        accept_second
);
  import regkey_pkg::*;

  localparam int unsigned CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  seq_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q;

  logic wr_first, wr_second, first_good, second_good;

  always_comb begin
    wr_first    = wr_en && hit_first;
    wr_second   = wr_en && hit_second;
    first_good  = wr_first && key_match(wdata, KEY_FIRST);
    second_good = wr_second && key_match(wdata, KEY_SECOND);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:   if (first_good) state_d = SEQ_ARMED;
      SEQ_ARMED: begin
        if (second_good)                  state_d = SEQ_SETTLE;
        else if (wr_second)               state_d = SEQ_IDLE;
        else if (wr_first && !first_good) state_d = SEQ_IDLE;
      end
      SEQ_SETTLE: if (cnt_q == CNT_LAST) state_d = SEQ_OPEN;
      SEQ_OPEN:   state_d = SEQ_OPEN;
      default:    state_d = SEQ_IDLE;
    endcase
  end

  always_comb begin
    armed         = (state_q == SEQ_ARMED);
    settling      = (state_q == SEQ_SETTLE);
    accept_second = armed && second_good;
    unlocked      = (state_q == SEQ_OPEN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept_second)  cnt_q <= '0;
      else if (settling)  cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/regkey_rdmux.sv
module regkey_rdmux (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic        hit_ctrl,
  input  logic        unlocked,
  output logic [31:0] rdata
);
  import regkey_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rdata <= '0;
    else if (rd_en && hit_ctrl) rdata <= status_word(unlocked);
    else                        rdata <= '0;
  end
endmodule

// File: rtl/regkey_unlock_guard.sv
module regkey_unlock_guard #(
  parameter int unsigned ADDR_W        = 6,
  parameter int unsigned SETTLE_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              unlocked,
  output logic              prot_wr_en
);
  logic dec_hit_first, dec_hit_second, dec_hit_ctrl;
  logic seq_armed, seq_settling, seq_accept;

  regkey_decode #(.ADDR_W(ADDR_W)) decode_i (
    .addr       (bus_addr),
    .hit_first  (dec_hit_first),
    .hit_second (dec_hit_second),
    .hit_ctrl   (dec_hit_ctrl)
  );

  regkey_seq #(.SETTLE_CYCLES(SETTLE_CYCLES)) seq_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (bus_wr_en),
    .hit_first     (dec_hit_first),
    .hit_second    (dec_hit_second),
    .wdata         (bus_wdata),
    .unlocked      (unlocked),
    .armed         (seq_armed),
    .settling      (seq_settling),
    .accept_second (seq_accept)
  );

  regkey_rdmux rdmux_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (bus_rd_en),
    .hit_ctrl (dec_hit_ctrl),
    .unlocked (unlocked),
    .rdata    (bus_rdata)
  );

  // Protected-register qualifier: kick registers are never passed through
  always_comb begin
    prot_wr_en = bus_wr_en && unlocked && !(dec_hit_first || dec_hit_second);
  end
endmodule

// File: rtl/regkey_unlock_guard_chk.sv
module regkey_unlock_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr_en,
  input logic        bus_rd_en,
  input logic [31:0] bus_rdata,
  input logic        unlocked,
  input logic        prot_wr_en,
  input logic        hit_ctrl,
  input logic        armed,
  input logic        settling,
  input logic        accept_second
);
  assert_reset_locked_R1: assert property (@(posedge clk) !rst_n |-> !unlocked && !prot_wr_en);

  assert_rise_after_settle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(settling));

  assert_accept_enters_settle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_second |=> settling);

  assert_status_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && hit_ctrl) |=> (bus_rdata[23] == $past(unlocked)) && ($countones(bus_rdata) <= 1));

  assert_other_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && !hit_ctrl) |=> bus_rdata == 32'h0);

  assert_locked_blocks_writes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> !prot_wr_en);

  assert_qual_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prot_wr_en |-> bus_wr_en);

  assert_second_needs_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_second |-> armed);

  assert_sticky_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |=> unlocked);
endmodule

bind regkey_unlock_guard regkey_unlock_guard_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_wr_en     (bus_wr_en),
  .bus_rd_en     (bus_rd_en),
  .bus_rdata     (bus_rdata),
  .unlocked      (unlocked),
  .prot_wr_en    (prot_wr_en),
  .hit_ctrl      (dec_hit_ctrl),
  .armed         (seq_armed),
  .settling      (seq_settling),
  .accept_second (seq_accept)
);

// File: tb/regkey_unlock_guard_tb_top.sv
`timescale 1ns/1ps
module regkey_unlock_guard_tb_top;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned SETTLE = 3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 6'h14;
  localparam logic [ADDR_W-1:0] A_K0    = 6'h1C;
  localparam logic [ADDR_W-1:0] A_K1    = 6'h1D;
  localparam logic [ADDR_W-1:0] A_OTHER = 6'h02;
  localparam logic [31:0] K0 = 32'h83E70B13;
  localparam logic [31:0] K1 = 32'h95A4F1E0;
  localparam logic [31:0] ST_OPEN = 32'h1 << 23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic unlocked, prot_wr_en;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  regkey_unlock_guard #(.ADDR_W(ADDR_W), .SETTLE_CYCLES(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(wr_en), .bus_rd_en(rd_en),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .unlocked(unlocked), .prot_wr_en(prot_wr_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Scoreboard for read responses
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic resp_due = 1'b0;
  always @(posedge clk) resp_due <= rd_en;
  always @(negedge clk) begin
    if (resp_due) begin
      if (exp_q.size() == 0) chk("scoreboard-underflow", 32'h1, 32'h0);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_probe(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                          input logic exp_q_en, input string req);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    #1 chk(req, {31'b0, prot_wr_en}, {31'b0, exp_q_en});
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_locked(input string req);
    idle(SETTLE + 1);
    chk(req, {31'b0, unlocked}, 32'h0);
    rd(A_CTRL, 32'h0, req);
  endtask

  initial begin : watchdog
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    // R1 reset state
    idle(3);
    chk("R1 unlocked", {31'b0, unlocked}, 32'h0);
    chk("R1 prot_wr_en", {31'b0, prot_wr_en}, 32'h0);
    chk("R1 rdata", rdata, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R5 writes ignored while locked
    wr_probe(A_OTHER, 32'h1234, 1'b0, "R5 locked other");
    wr_probe(A_CTRL, 32'hFFFF_FFFF, 1'b0, "R5 locked ctrl");

    // R8 second key alone, then reverse order
    wr(A_K1, K1);
    expect_locked("R8 second alone");
    wr(A_K1, K1); wr(A_K0, K0);
    expect_locked("R8 reverse order");
    wr(A_K0, 32'h0);               // clear the progress left by the reverse order

    // R6 bad first key cancels
    wr(A_K0, K0); wr(A_K0, 32'hDEAD_BEEF); wr(A_K1, K1);
    expect_locked("R6 bad first");
    wr(A_K0, K0); wr(A_K0, K1); wr(A_K1, K1);
    expect_locked("R6 swapped key");

    // R7 bad second key cancels
    wr(A_K0, K0); wr(A_K1, 32'h0000_0001); wr(A_K1, K1);
    expect_locked("R7 bad second");

    // R4 kick and other reads are zero
    rd(A_K0, 32'h0, "R4 kick0 read");
    rd(A_K1, 32'h0, "R4 kick1 read");
    rd(A_OTHER, 32'h0, "R4 other read");

    // R10 unrelated writes between keys, then R2 timed rise
    wr(A_K0, K0);
    wr(A_OTHER, 32'h5555_AAAA);
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, 32'h0, "R10 still locked mid-sequence");
    wr(A_K1, K1);
    chk("R2 edge+0", {31'b0, unlocked}, 32'h0);
    for (int k = 1; k <= SETTLE; k++) begin
      @(negedge clk);
      chk("R2 R10 settle window", {31'b0, unlocked}, {31'b0, (k == SETTLE)});
    end

    // R3 status readback
    rd(A_CTRL, ST_OPEN, "R3 status open");

    // R5 qualifier while unlocked
    wr_probe(A_OTHER, 32'h1, 1'b1, "R5 open other");
    wr_probe(A_CTRL, 32'h1, 1'b1, "R5 open ctrl");
    wr_probe(A_K0, K0, 1'b0, "R5 open kick0");
    wr_probe(A_K1, K1, 1'b0, "R5 open kick1");

    // R9 no relock
    wr(A_K0, 32'h0); wr(A_K1, 32'h0); wr(A_K1, K1);
    idle(SETTLE + 1);
    chk("R9 sticky", {31'b0, unlocked}, 32'h1);
    rd(A_CTRL, ST_OPEN, "R9 status");

    // R1 reset relocks
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R1 relock", {31'b0, unlocked}, 32'h0);
    chk("R1 relock rdata", rdata, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    rd(A_CTRL, 32'h0, "R1 status after reset");

    idle(3);
    chk("scoreboard drained", exp_q.size(), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule